// File: doc/BRIEF.md
# SPI Slave Byte Datapath

This block is the data path of a serial peripheral slave. Software places a byte in a transmit holding register. The block moves that byte into a shift register only when the shift register has no word of its own and no frame is in progress. It then shifts the byte out on MISO, most significant bit first, while the master toggles the serial clock with slave select held low. The master's MOSI bits are collected into a receive shift register at the same time. At the end of each byte, the received value is copied to a receive holding register and a receive-ready flag is raised.

The serial clock mode is fixed. The clock idles low, the slave changes MISO after each falling edge, and both sides sample on the rising edge. The serial inputs are synchronised into the system clock, and edges are detected there, so the serial clock must be several times slower than `clk_i`. A word that is waiting is never replaced. A write that arrives while the holding register is full is dropped. A frame cut short by slave select is abandoned, and its word is sent again from the start at the next select.

Top module: `spi_slv_dp`

## Requirements
- R1: After reset, tx_empty_o is 1, rx_ready_o is 0, rx_data_o is 0, miso_oe_o is 0 and miso_o is 0.
- R2: A write with tx_empty_o = 1 makes tx_empty_o read 0 after the next clock edge. When the shift register is free and no frame is in progress, the byte moves into it and tx_empty_o returns to 1 one edge later.
- R3: A byte written while the shift register holds an unsent or in-progress word stays in the holding register with tx_empty_o = 0. It moves into the shift register only after the current frame has completed.
- R4: A write presented while tx_empty_o = 0 is ignored, and the held byte is the one transmitted next.
- R5: A byte loaded into the shift register is never replaced by a later write before its own frame has been fully shifted out.
- R6: While selected (ss_ni = 0), miso_oe_o is 1 and miso_o carries the loaded byte MSB first. The MSB is present before the first rising edge, and each following bit appears after a falling edge. While deselected, both outputs are 0.
- R7: MOSI is sampled on each rising edge of sck_i, MSB first. After the 8th rising edge of a frame, rx_data_o holds the byte and rx_ready_o is 1.
- R8: A pulse on rd_en_i clears rx_ready_o after the next clock edge.
- R9: Raising ss_ni before 8 bits have been shifted abandons the frame. The bit counter is reset, rx_ready_o is not set, and the interrupted byte is sent again from its MSB in the next frame.
- R10: A frame that runs with no loaded byte drives miso_o = 0 for every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the transmit holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| tx_empty_o | output | 1 | Transmit holding register is free |
| rd_en_i | input | 1 | Acknowledge of the received byte; clears rx_ready_o |
| rx_data_o | output | DATA_W | Last complete received byte |
| rx_ready_o | output | 1 | A received byte is waiting |
| sck_i | input | 1 | Serial clock from the master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o |

## Verification
Several properties are checked on every clock cycle:
- A waiting byte in the holding register does not change until it is loaded.
- A loaded word stays loaded and unchanged until its frame ends.
- The empty flag is set after each load.
- The ready flag rises after each completed frame and falls after an acknowledge.

Some behaviours can only be shown by the bench's scenarios:
- The bit order seen on MISO.
- Resending a word after an aborted frame.
- Zero data on an underrun.
- Round-trip correctness of every one of the 256 byte values in both directions.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // Per-cycle serial events seen in the system clock domain
  typedef struct packed {
    logic sel;       // slave selected
    logic sample;    // rising edge while selected
    logic shift;     // falling edge inside a frame
    logic done;      // last rising edge of a frame
    logic at_start;  // bit counter at frame boundary
    logic mosi;      // synchronised MOSI, aligned with sck
  } spi_evt_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync
  import spi_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_i,
  input  logic     ss_ni,
  input  logic     mosi_i,
  output spi_evt_t evt_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sck_q, ss_q, mosi_q;
  logic sck_prev;
  logic [CNT_W-1:0] bit_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_q  <= '0;
          ss_q   <= '1;
          mosi_q <= '0;
        end else begin
          sck_q  <= sck_i;
          ss_q   <= ss_ni;
          mosi_q <= mosi_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_q  <= '0;
          ss_q   <= '1;
          mosi_q <= '0;
        end else begin
          sck_q  <= {sck_q[SYNC_STAGES-2:0], sck_i};
          ss_q   <= {ss_q[SYNC_STAGES-2:0], ss_ni};
          mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_i};
        end
      end
    end
  endgenerate

  logic sck_s, sel, rise, fall;
  assign sck_s = sck_q[SYNC_STAGES-1];
  assign sel   = !ss_q[SYNC_STAGES-1];
  assign rise  = sck_s && !sck_prev;
  assign fall  = !sck_s && sck_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      sck_prev <= sck_s;
      if (!sel)                           bit_cnt <= '0;
      else if (rise && bit_cnt == LAST)   bit_cnt <= '0;
      else if (rise)                      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign evt_o.sel      = sel;
  assign evt_o.sample   = sel && rise;
  assign evt_o.shift    = sel && fall && (bit_cnt != '0);
  assign evt_o.done     = sel && rise && (bit_cnt == LAST);
  assign evt_o.at_start = (bit_cnt == '0);
  assign evt_o.mosi     = mosi_q[SYNC_STAGES-1];
endmodule

// File: rtl/spi_slv_tx.sv
module spi_slv_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sel_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              done_i,
  input  logic              start_i,
  output logic              miso_o,
  output logic              tx_empty_o
);
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              sh_loaded;
  logic [DATA_W-1:0] sh_word;   // copy kept for resend after abort
  logic [DATA_W-1:0] sh_data;
  logic              accept, load;

  assign accept = wr_en_i && !hold_valid;
  // Move only at a frame boundary and only into a free shifter
  assign load   = hold_valid && !sh_loaded && start_i && !sample_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (accept) begin
      hold_valid <= 1'b1;
      hold_data  <= wr_data_i;
    end else if (load) begin
      hold_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_loaded <= 1'b0;
      sh_word   <= '0;
      sh_data   <= '0;
    end else if (load) begin
      sh_loaded <= 1'b1;
      sh_word   <= hold_data;
      sh_data   <= hold_data;
    end else if (done_i) begin
      sh_loaded <= 1'b0;
      sh_word   <= '0;
      sh_data   <= '0;
    end else if (!sel_i) begin
      sh_data   <= sh_word;     // abandon partial frame, rewind
    end else if (shift_i) begin
      sh_data   <= {sh_data[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_o     = sh_data[DATA_W-1];
  assign tx_empty_o = !hold_valid;

  a_r4_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid && !load) |=> (hold_valid && $stable(hold_data)));
  a_r5_word_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_loaded && !done_i) |=> (sh_loaded && $stable(sh_word)));
  a_r2_empty_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> tx_empty_o);
  a_r3_wait_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid && sh_loaded) |=> !tx_empty_o);
endmodule

// File: rtl/spi_slv_rx.sv
module spi_slv_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              done_i,
  input  logic              mosi_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o
);
  logic [DATA_W-1:0] rx_shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_shift   <= '0;
      rx_data_o  <= '0;
      rx_ready_o <= 1'b0;
    end else begin
      if (sample_i) rx_shift <= {rx_shift[DATA_W-2:0], mosi_i};
      if (done_i) begin
        rx_data_o  <= {rx_shift[DATA_W-2:0], mosi_i};
        rx_ready_o <= 1'b1;
      end else if (rd_en_i) begin
        rx_ready_o <= 1'b0;
      end
    end
  end

  a_r7_ready_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rx_ready_o);
  a_r8_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !done_i) |=> !rx_ready_o);
endmodule

// File: rtl/spi_slv_dp.sv
module spi_slv_dp
  import spi_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_empty_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  spi_evt_t evt;
  logic     tx_bit;

  spi_slv_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_i),
    .ss_ni (ss_ni),
    .mosi_i(mosi_i),
    .evt_o (evt)
  );

  spi_slv_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sel_i     (evt.sel),
    .sample_i  (evt.sample),
    .shift_i   (evt.shift),
    .done_i    (evt.done),
    .start_i   (evt.at_start),
    .miso_o    (tx_bit),
    .tx_empty_o(tx_empty_o)
  );

  spi_slv_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (evt.sample),
    .done_i    (evt.done),
    .mosi_i    (evt.mosi),
    .rd_en_i   (rd_en_i),
    .rx_data_o (rx_data_o),
    .rx_ready_o(rx_ready_o)
  );

  assign miso_oe_o = evt.sel;
  assign miso_o    = evt.sel && tx_bit;

  a_r6_quiet_unsel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);
endmodule

// File: tb/spi_slv_dp_tb.sv
module spi_slv_dp_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       sck = 1'b0;
  logic       ss_n = 1'b1;
  logic       mosi = 1'b0;
  logic       tx_empty, rx_ready, miso, miso_oe;
  logic [7:0] rx_data;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_slv_dp u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .tx_empty_o(tx_empty),
    .rd_en_i   (rd_en),
    .rx_data_o (rx_data),
    .rx_ready_o(rx_ready),
    .sck_i     (sck),
    .ss_ni     (ss_n),
    .mosi_i    (mosi),
    .miso_o    (miso),
    .miso_oe_o (miso_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic read_ack();
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  // Master side, idle-low clock; reads MISO just before each rising edge
  task automatic frame(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    ss_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[7-i];
      tick(8);
      mi[7-i] = miso;
      sck = 1'b1;
      tick(8);
      sck = 1'b0;
    end
    tick(8);
    ss_n = 1'b1;
    tick(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    tick(3);
    // R1 reset state
    check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    check(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
    check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    check(miso_oe == 1'b0, "R1 miso_oe", miso_oe, 0);
    check(miso == 1'b0, "R1 miso", miso, 0);
    rst_ni = 1'b1;
    tick(4);

    // R2 write into idle block
    write_byte(8'hA5);
    check(tx_empty == 1'b0, "R2 flag low after write", tx_empty, 0);
    tick(1);
    check(tx_empty == 1'b1, "R2 flag high after load", tx_empty, 1);

    // R3 second byte waits behind busy shifter
    write_byte(8'h3C);
    tick(5);
    check(tx_empty == 1'b0, "R3 byte waits", tx_empty, 0);
    // R4 write while full is dropped
    write_byte(8'hFF);
    tick(2);
    check(tx_empty == 1'b0, "R4 still full", tx_empty, 0);

    // R5/R6/R7 first frame carries A5
    frame(8'hC3, 8, got);
    check(got == 8'hA5, "R5 R6 miso byte", got, 8'hA5);
    check(rx_data == 8'hC3, "R7 rx_data", rx_data, 8'hC3);
    check(rx_ready == 1'b1, "R7 rx_ready", rx_ready, 1);
    check(tx_empty == 1'b1, "R3 moved after frame", tx_empty, 1);

    // R8 acknowledge
    read_ack();
    check(rx_ready == 1'b0, "R8 cleared", rx_ready, 0);

    // R4 next frame carries 3C, not FF
    frame(8'h00, 8, got);
    check(got == 8'h3C, "R4 held byte sent", got, 8'h3C);
    check(rx_data == 8'h00, "R7 rx zero", rx_data, 0);
    read_ack();

    // R10 underrun
    frame(8'h81, 8, got);
    check(got == 8'h00, "R10 underrun zeros", got, 0);
    check(rx_data == 8'h81, "R7 rx during underrun", rx_data, 8'h81);
    read_ack();

    // R6 output enable follows select
    ss_n = 1'b0;
    tick(8);
    check(miso_oe == 1'b1, "R6 oe selected", miso_oe, 1);
    ss_n = 1'b1;
    tick(8);
    check(miso_oe == 1'b0, "R6 oe deselected", miso_oe, 0);

    // R9 aborted frame, then full resend
    write_byte(8'h96);
    tick(3);
    frame(8'hF0, 3, got);
    check(got[7:5] == 3'b100, "R9 partial bits", got[7:5], 3'b100);
    check(rx_ready == 1'b0, "R9 no ready on abort", rx_ready, 0);
    frame(8'h5A, 8, got);
    check(got == 8'h96, "R9 resend from MSB", got, 8'h96);
    check(rx_data == 8'h5A, "R9 counter reset", rx_data, 8'h5A);
    check(rx_ready == 1'b1, "R9 R7 ready after full", rx_ready, 1);
    read_ack();

    // R6 R7 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      write_byte(8'(v));
      tick(2);
      frame(~8'(v) ^ 8'h24, 8, got);
      check(got == 8'(v), "R6 sweep miso", got, v);
      check(rx_data == (~8'(v) ^ 8'h24), "R7 sweep rx", rx_data, ~8'(v) ^ 8'h24);
      read_ack();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule